// File: doc/BRIEF.md
# Associative register rename unit

This unit gives each architectural register a home among the rows of a physical register file. Every physical row carries a tag that names the architectural register it currently represents. It also carries a count of the in-flight readers of the value in that row and a generation stamp. A source operand is resolved by searching every row's tag at once, so no indexed map table exists. Only a destination operand ever places a register into a row. Each architectural register owns at most one row at any time, and physical row 0 is never handed out. A source that finds no row reports a not-written condition and receives index 0, which the data array keeps at zero.

Each cycle the unit takes one request with two optional sources and one optional destination. A destination whose register already owns a row reuses that row in place, but only once no reader of the old value remains. A destination without a row takes the lowest-numbered empty row. When no row is empty, it takes the row of the least recently used architectural register whose row has no readers. The release input retires one reader of a row. The flush input discards every row allocated after a given generation. The query port shows the tag and status of any row to a scheduler.

Top module: `rr_rename_cam`

## Requirements
- R1: After reset every row reads as invalid with a reader count of 0, and every enabled source lookup reports not-written.
- R2: An enabled source whose register owns a row returns that row's index with not-written low. A source never creates, moves or removes a mapping.
- R3: An enabled source whose register owns no row raises its not-written flag and returns index 0. A disabled source returns index 0 with the flag low.
- R4: A destination whose register owns a row with a reader count of 0 is given that same row, with dst_kind = 1 (reuse).
- R5: A destination whose register owns a row with a nonzero reader count holds req_ready low.
- R6: A destination whose register owns no row is given the lowest-indexed invalid row at index 1 or above, with dst_kind = 2 (free). dst_kind is 0 and dst_idx is 0 whenever dst_en or req_ready is low.
- R7: With no invalid row left, the destination is given, with dst_kind = 3 (evict), the row of the least recently used architectural register among rows that have a reader count of 0 and are not a source of this request. The evicted register then owns no row. Recency is refreshed on each accepted request for source 0 (on a hit), then source 1 (on a hit), then the destination. After reset, a higher-numbered register counts as more recent. If no row qualifies, req_ready is low.
- R8: An accepted request adds one to the reader count of the row of each source that hits. A release lowers the named row's count by one and is ignored when the count is 0. req_ready is low when an increment would exceed 2^CW-1.
- R9: Flush invalidates every valid row whose generation is above flush_gen and clears every reader count. req_ready is low in the flush cycle and no request is accepted.
- R10: The query port shows the valid bit, tag, reader count and generation of row qry_idx in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Rename request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| src0_en | input | 1 | Source 0 in use |
| src0_arch | input | AW | Source 0 architectural register |
| src1_en | input | 1 | Source 1 in use |
| src1_arch | input | AW | Source 1 architectural register |
| dst_en | input | 1 | Destination in use |
| dst_arch | input | AW | Destination architectural register |
| req_gen | input | GW | Generation recorded in an allocated row |
| src0_idx | output | PW | Row found for source 0 |
| src0_nw | output | 1 | Source 0 register never written |
| src1_idx | output | PW | Row found for source 1 |
| src1_nw | output | 1 | Source 1 register never written |
| dst_idx | output | PW | Row given to the destination |
| dst_kind | output | 2 | 0 none, 1 reuse, 2 free, 3 evict |
| rel_valid | input | 1 | Release one reader |
| rel_idx | input | PW | Row whose reader is released |
| flush | input | 1 | Discard rows newer than flush_gen |
| flush_gen | input | GW | Generation kept by a flush |
| qry_idx | input | PW | Row to inspect |
| qry_valid | output | 1 | Row valid bit |
| qry_tag | output | AW | Row architectural tag |
| qry_cnt | output | CW | Row reader count |
| qry_gen | output | GW | Row generation |

## Verification
The bench runs a small configuration with eight registers and four allocatable rows, so eviction happens constantly. It drives long random mixes of paired sources, same-register source and destination, releases aimed at the few rows, and occasional flushes against an integer model that tracks recency as increasing stamps. Source patterns tell a hit apart from a never-written register. Destination patterns tell in-place reuse apart from a blocked reuse, a free row apart from an eviction, and a legal victim apart from one excluded by readers or by being a source. Reader-count stress with a 2-bit counter separates a saturation stall from a reuse stall, and flushes with random generations show which rows survive.

// File: rtl/rr_pkg.sv
package rr_pkg;
  typedef enum logic [1:0] {
    DK_NONE  = 2'd0,
    DK_REUSE = 2'd1,
    DK_FREE  = 2'd2,
    DK_EVICT = 2'd3
  } dst_kind_e;

  // reader count stays within its counter after adding incr
  function automatic bit count_fits(int cnt, int incr, int cw);
    return (cnt + incr) <= ((1 << cw) - 1);
  endfunction
endpackage

// File: rtl/rr_cam_search.sv
module rr_cam_search #(
  parameter int NPHYS = 512,
  parameter int NARCH = 64,
  localparam int AW = $clog2(NARCH),
  localparam int PW = $clog2(NPHYS)
) (
  input  logic          en,
  input  logic [AW-1:0] key,
  input  logic          row_v   [NPHYS],
  input  logic [AW-1:0] row_tag [NPHYS],
  output logic          hit,
  output logic [PW-1:0] idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int r = NPHYS - 1; r >= 1; r--) begin
      if (en && row_v[r] && row_tag[r] == key) begin
        hit = 1'b1;
        idx = PW'(r);
      end
    end
  end
endmodule

// File: rtl/rr_victim.sv
module rr_victim #(
  parameter int NPHYS = 512,
  parameter int NARCH = 64,
  localparam int AW = $clog2(NARCH),
  localparam int PW = $clog2(NPHYS)
) (
  input  logic                        row_v    [NPHYS],
  input  logic [AW-1:0]               row_tag  [NPHYS],
  input  logic                        cand_row [NPHYS],
  input  logic [NARCH-1:0][NARCH-1:0] age,
  output logic                        free_hit,
  output logic [PW-1:0]               free_idx,
  output logic                        lru_hit,
  output logic [PW-1:0]               lru_idx
);
  logic [NARCH-1:0] cand_arch;
  logic [NARCH-1:0] is_lru;
  logic [AW-1:0]    lru_arch;
  logic             lru_found;

  always_comb begin
    free_hit = 1'b0;
    free_idx = '0;
    for (int r = NPHYS - 1; r >= 1; r--) begin
      if (!row_v[r]) begin
        free_hit = 1'b1;
        free_idx = PW'(r);
      end
    end
  end

  always_comb begin
    cand_arch = '0;
    for (int r = 1; r < NPHYS; r++)
      if (cand_row[r]) cand_arch[row_tag[r]] = 1'b1;
  end

  // age[b][a] set: b was used more recently than a
  always_comb begin
    for (int a = 0; a < NARCH; a++) begin
      is_lru[a] = cand_arch[a];
      for (int b = 0; b < NARCH; b++)
        if (b != a && cand_arch[b] && !age[b][a]) is_lru[a] = 1'b0;
    end
    lru_found = 1'b0;
    lru_arch  = '0;
    for (int a = NARCH - 1; a >= 0; a--) begin
      if (is_lru[a]) begin
        lru_found = 1'b1;
        lru_arch  = AW'(a);
      end
    end
  end

  logic          lru_row_hit;
  rr_cam_search #(.NPHYS(NPHYS), .NARCH(NARCH)) u_lru_row (
    .en(lru_found), .key(lru_arch), .row_v(cand_row), .row_tag(row_tag),
    .hit(lru_row_hit), .idx(lru_idx)
  );
  assign lru_hit = lru_row_hit;
endmodule

// File: rtl/rr_rename_cam.sv
module rr_rename_cam
  import rr_pkg::*;
#(
  parameter int NARCH = 64,
  parameter int NPHYS = 512,
  parameter int CW    = 4,
  parameter int GW    = 3,
  localparam int AW = $clog2(NARCH),
  localparam int PW = $clog2(NPHYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          src0_en,
  input  logic [AW-1:0] src0_arch,
  input  logic          src1_en,
  input  logic [AW-1:0] src1_arch,
  input  logic          dst_en,
  input  logic [AW-1:0] dst_arch,
  input  logic [GW-1:0] req_gen,
  output logic [PW-1:0] src0_idx,
  output logic          src0_nw,
  output logic [PW-1:0] src1_idx,
  output logic          src1_nw,
  output logic [PW-1:0] dst_idx,
  output logic [1:0]    dst_kind,
  input  logic          rel_valid,
  input  logic [PW-1:0] rel_idx,
  input  logic          flush,
  input  logic [GW-1:0] flush_gen,
  input  logic [PW-1:0] qry_idx,
  output logic          qry_valid,
  output logic [AW-1:0] qry_tag,
  output logic [CW-1:0] qry_cnt,
  output logic [GW-1:0] qry_gen
);
  typedef logic [NARCH-1:0][NARCH-1:0] age_t;

  logic          row_v   [NPHYS];
  logic [AW-1:0] row_tag [NPHYS];
  logic [CW-1:0] row_cnt [NPHYS];
  logic [GW-1:0] row_gen [NPHYS];
  age_t          age_q, age_d;

  logic          s0_hit, s1_hit, d_hit;
  logic [PW-1:0] s0_row, s1_row, d_row;
  logic [1:0]    inc      [NPHYS];
  logic          dec      [NPHYS];
  logic          cand_row [NPHYS];
  logic          free_hit, lru_hit;
  logic [PW-1:0] free_idx, lru_idx, pick;
  dst_kind_e     kind_raw;
  logic          dst_ok, sat_ok;

  // named events for the checker
  logic accept, alloc_fire, evict_fire;

  rr_cam_search #(.NPHYS(NPHYS), .NARCH(NARCH)) u_src0 (
    .en(src0_en), .key(src0_arch), .row_v(row_v), .row_tag(row_tag),
    .hit(s0_hit), .idx(s0_row));
  rr_cam_search #(.NPHYS(NPHYS), .NARCH(NARCH)) u_src1 (
    .en(src1_en), .key(src1_arch), .row_v(row_v), .row_tag(row_tag),
    .hit(s1_hit), .idx(s1_row));
  rr_cam_search #(.NPHYS(NPHYS), .NARCH(NARCH)) u_dst (
    .en(dst_en), .key(dst_arch), .row_v(row_v), .row_tag(row_tag),
    .hit(d_hit), .idx(d_row));

  always_comb begin
    for (int r = 0; r < NPHYS; r++) begin
      inc[r] = {1'b0, s0_hit && s0_row == PW'(r)} + {1'b0, s1_hit && s1_row == PW'(r)};
      dec[r] = rel_valid && rel_idx == PW'(r) && row_cnt[r] != '0;
      cand_row[r] = row_v[r] && row_cnt[r] == '0 && inc[r] == 2'd0;
    end
  end

  rr_victim #(.NPHYS(NPHYS), .NARCH(NARCH)) u_victim (
    .row_v(row_v), .row_tag(row_tag), .cand_row(cand_row), .age(age_q),
    .free_hit(free_hit), .free_idx(free_idx), .lru_hit(lru_hit), .lru_idx(lru_idx));

  assign sat_ok = (!s0_hit || count_fits(int'(row_cnt[s0_row]), int'(inc[s0_row]), CW)) &&
                  (!s1_hit || count_fits(int'(row_cnt[s1_row]), int'(inc[s1_row]), CW));

  always_comb begin
    kind_raw = DK_NONE;
    pick     = '0;
    dst_ok   = 1'b0;
    if (d_hit) begin
      kind_raw = DK_REUSE;
      pick     = d_row;
      dst_ok   = row_cnt[d_row] == '0;
    end else if (free_hit) begin
      kind_raw = DK_FREE;
      pick     = free_idx;
      dst_ok   = 1'b1;
    end else if (lru_hit) begin
      kind_raw = DK_EVICT;
      pick     = lru_idx;
      dst_ok   = 1'b1;
    end
  end

  assign req_ready  = !flush && sat_ok && (!dst_en || dst_ok);
  assign accept     = req_valid && req_ready;
  assign alloc_fire = accept && dst_en;
  assign evict_fire = alloc_fire && kind_raw == DK_EVICT;

  assign src0_idx = s0_row;
  assign src0_nw  = src0_en && !s0_hit;
  assign src1_idx = s1_row;
  assign src1_nw  = src1_en && !s1_hit;
  assign dst_kind = (req_ready && dst_en) ? kind_raw : DK_NONE;
  assign dst_idx  = (req_ready && dst_en) ? pick : '0;

  assign qry_valid = row_v[qry_idx];
  assign qry_tag   = row_tag[qry_idx];
  assign qry_cnt   = row_cnt[qry_idx];
  assign qry_gen   = row_gen[qry_idx];

  function automatic age_t touch(age_t m, logic [AW-1:0] a);
    for (int b = 0; b < NARCH; b++) begin
      m[a][b] = 1'b1;
      m[b][a] = 1'b0;
    end
    return m;
  endfunction

  always_comb begin
    age_d = age_q;
    if (s0_hit) age_d = touch(age_d, src0_arch);
    if (s1_hit) age_d = touch(age_d, src1_arch);
    if (dst_en) age_d = touch(age_d, dst_arch);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NPHYS; r++) begin
        row_v[r]   <= 1'b0;
        row_tag[r] <= '0;
        row_cnt[r] <= '0;
        row_gen[r] <= '0;
      end
      for (int a = 0; a < NARCH; a++)
        for (int b = 0; b < NARCH; b++)
          age_q[a][b] <= (a > b);
    end else if (flush) begin
      for (int r = 0; r < NPHYS; r++) begin
        row_v[r]   <= row_v[r] && !(row_gen[r] > flush_gen);
        row_cnt[r] <= '0;
      end
    end else begin
      for (int r = 0; r < NPHYS; r++)
        row_cnt[r] <= row_cnt[r] + (accept ? CW'(inc[r]) : CW'(0)) - CW'(dec[r]);
      if (alloc_fire) begin
        row_v[pick]   <= 1'b1;
        row_tag[pick] <= dst_arch;
        row_gen[pick] <= req_gen;
      end
      if (accept) age_q <= age_d;
    end
  end
endmodule

// File: rtl/rr_rename_chk.sv
module rr_rename_chk #(
  parameter int NPHYS = 512,
  parameter int CW    = 4,
  localparam int PW = $clog2(NPHYS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush,
  input logic          req_ready,
  input logic          dst_en,
  input logic [PW-1:0] dst_idx,
  input logic [1:0]    dst_kind,
  input logic          src0_nw,
  input logic [PW-1:0] src0_idx,
  input logic          accept,
  input logic          alloc_fire,
  input logic          rel_valid,
  input logic [PW-1:0] rel_idx,
  input logic          row_v   [NPHYS],
  input logic [CW-1:0] row_cnt [NPHYS]
);
  // R9
  flush_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !req_ready);

  // R3
  nw_row_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src0_nw |-> src0_idx == '0);

  // R6
  dst_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && dst_en) |-> (dst_idx != '0 && dst_kind != 2'd0));

  // R4
  alloc_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |=> row_v[$past(dst_idx)]);

  // R8
  release_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_valid && !flush && !accept && row_cnt[rel_idx] == '0) |=> row_cnt[$past(rel_idx)] == '0);
endmodule

bind rr_rename_cam rr_rename_chk #(.NPHYS(NPHYS), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .req_ready(req_ready),
  .dst_en(dst_en), .dst_idx(dst_idx), .dst_kind(dst_kind),
  .src0_nw(src0_nw), .src0_idx(src0_idx), .accept(accept),
  .alloc_fire(alloc_fire), .rel_valid(rel_valid), .rel_idx(rel_idx),
  .row_v(row_v), .row_cnt(row_cnt)
);

// File: tb/tb_rr_rename_cam.sv
`timescale 1ns/1ps
module tb_rr_rename_cam;
  localparam int NA = 8, NP = 5, CW = 2, GW = 2, AW = 3, PW = 3;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, src0_en = 0, src1_en = 0, dst_en = 0;
  logic [AW-1:0] src0_arch = 0, src1_arch = 0, dst_arch = 0;
  logic [GW-1:0] req_gen = 0, flush_gen = 0;
  logic rel_valid = 0, flush = 0;
  logic [PW-1:0] rel_idx = 0, qry_idx = 0;
  logic req_ready, src0_nw, src1_nw, qry_valid;
  logic [PW-1:0] src0_idx, src1_idx, dst_idx;
  logic [1:0] dst_kind;
  logic [AW-1:0] qry_tag;
  logic [CW-1:0] qry_cnt;
  logic [GW-1:0] qry_gen;

  always #2.5 clk = ~clk;

  rr_rename_cam #(.NARCH(NA), .NPHYS(NP), .CW(CW), .GW(GW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .src0_en(src0_en), .src0_arch(src0_arch), .src1_en(src1_en), .src1_arch(src1_arch),
    .dst_en(dst_en), .dst_arch(dst_arch), .req_gen(req_gen),
    .src0_idx(src0_idx), .src0_nw(src0_nw), .src1_idx(src1_idx), .src1_nw(src1_nw),
    .dst_idx(dst_idx), .dst_kind(dst_kind), .rel_valid(rel_valid), .rel_idx(rel_idx),
    .flush(flush), .flush_gen(flush_gen), .qry_idx(qry_idx), .qry_valid(qry_valid),
    .qry_tag(qry_tag), .qry_cnt(qry_cnt), .qry_gen(qry_gen));

  int tests = 0, fails = 0;
  int mv [NP], mtag [NP], mcnt [NP], mgen [NP];
  int stamp [NA];
  int tnext;
  int e0, e1, dr, xkind, xpick, xinc [NP];
  bit dok, sat, xready;

  task automatic chk(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int mfind(int a);
    for (int r = 1; r < NP; r++)
      if (mv[r] != 0 && mtag[r] == a) return r;
    return 0;
  endfunction

  task automatic predict();
    int best;
    e0 = src0_en ? mfind(int'(src0_arch)) : 0;
    e1 = src1_en ? mfind(int'(src1_arch)) : 0;
    for (int r = 0; r < NP; r++) xinc[r] = 0;
    if (e0 != 0) xinc[e0]++;
    if (e1 != 0) xinc[e1]++;
    sat = 1;
    for (int r = 1; r < NP; r++)
      if (xinc[r] != 0 && mcnt[r] + xinc[r] > CMAX) sat = 0;
    dr = mfind(int'(dst_arch));
    xkind = 0; xpick = 0; dok = 0;
    if (dr != 0) begin
      xkind = 1; xpick = dr; dok = (mcnt[dr] == 0);
    end else begin
      for (int r = NP - 1; r >= 1; r--)
        if (mv[r] == 0) begin xkind = 2; xpick = r; dok = 1; end
      if (xkind == 0) begin
        best = 1 << 30;
        for (int r = 1; r < NP; r++)
          if (mv[r] != 0 && mcnt[r] == 0 && xinc[r] == 0 && stamp[mtag[r]] < best) begin
            best = stamp[mtag[r]]; xkind = 3; xpick = r; dok = 1;
          end
      end
    end
    xready = !flush && sat && (!dst_en || dok);
  endtask

  task automatic update();
    bit acc;
    int nc;
    if (flush) begin
      for (int r = 1; r < NP; r++) begin
        if (mgen[r] > int'(flush_gen)) mv[r] = 0;
        mcnt[r] = 0;
      end
      return;
    end
    acc = req_valid && xready;
    for (int r = 1; r < NP; r++) begin
      nc = mcnt[r] + (acc ? xinc[r] : 0);
      if (rel_valid && int'(rel_idx) == r && mcnt[r] > 0) nc--;
      mcnt[r] = nc;
    end
    if (acc && dst_en) begin
      mv[xpick] = 1; mtag[xpick] = int'(dst_arch); mgen[xpick] = int'(req_gen);
    end
    if (acc) begin
      if (e0 != 0) stamp[src0_arch] = tnext++;
      if (e1 != 0) stamp[src1_arch] = tnext++;
      if (dst_en) stamp[dst_arch] = tnext++;
    end
  endtask

  task automatic check_outputs();
    string rq;
    chk(src0_nw ? "R3" : "R2", "src0_idx", int'(src0_idx), e0);
    chk(src0_en && e0 == 0 ? "R3" : "R2", "src0_nw", int'(src0_nw), int'(src0_en && e0 == 0));
    chk(e1 != 0 ? "R2" : "R3", "src1_idx", int'(src1_idx), e1);
    chk("R3", "src1_nw", int'(src1_nw), int'(src1_en && e1 == 0));
    if (flush) rq = "R9";
    else if (!sat) rq = "R8";
    else if (dst_en && dr != 0 && !dok) rq = "R5";
    else if (dst_en && xkind == 3) rq = "R7";
    else rq = "R6";
    chk(rq, "req_ready", int'(req_ready), int'(xready));
    if (xkind == 1) rq = "R4";
    else if (xkind == 3) rq = "R7";
    else rq = "R6";
    chk(rq, "dst_kind", int'(dst_kind), (xready && dst_en) ? xkind : 0);
    chk(rq, "dst_idx", int'(dst_idx), (xready && dst_en) ? xpick : 0);
    chk("R10", "qry_valid", int'(qry_valid), mv[qry_idx]);
    chk("R10", "qry_cnt", int'(qry_cnt), mcnt[qry_idx]);
    if (mv[qry_idx] != 0) begin
      chk("R10", "qry_tag", int'(qry_tag), mtag[qry_idx]);
      chk("R10", "qry_gen", int'(qry_gen), mgen[qry_idx]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int r = 0; r < NP; r++) begin mv[r] = 0; mtag[r] = 0; mcnt[r] = 0; mgen[r] = 0; end
    for (int a = 0; a < NA; a++) stamp[a] = a;
    tnext = NA;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: every row empty, every register unwritten
    for (int r = 0; r < NP; r++) begin
      @(negedge clk);
      qry_idx = PW'(r);
      #1;
      chk("R1", "qry_valid after reset", int'(qry_valid), 0);
      chk("R1", "qry_cnt after reset", int'(qry_cnt), 0);
    end
    for (int a = 0; a < NA; a++) begin
      @(negedge clk);
      src0_en = 1'b1; src0_arch = AW'(a);
      #1;
      chk("R1", "src0_nw after reset", int'(src0_nw), 1);
      chk("R1", "src0_idx after reset", int'(src0_idx), 0);
    end

    for (int cyc = 0; cyc < 6000; cyc++) begin
      @(negedge clk);
      req_valid = ($urandom % 8) != 0;
      src0_en   = ($urandom % 4) != 0;
      src1_en   = ($urandom % 2) != 0;
      dst_en    = ($urandom % 4) != 0;
      src0_arch = AW'($urandom % NA);
      src1_arch = ($urandom % 4 == 0) ? src0_arch : AW'($urandom % NA);
      dst_arch  = ($urandom % 5 == 0) ? src0_arch : AW'($urandom % NA);
      req_gen   = GW'($urandom % 4);
      rel_valid = ($urandom % 3) != 0;
      rel_idx   = PW'(1 + $urandom % (NP - 1));
      flush     = ($urandom % 40) == 0;
      flush_gen = GW'($urandom % 4);
      qry_idx   = PW'(cyc % NP);
      #1;
      predict();
      check_outputs();
      @(posedge clk);
      update();
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule